// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between a set of up to 32 peripheral interrupt lines and a parent interrupt controller. Each source that belongs to an aggregation group is captured on its rising edge into a pending word. It is qualified by an enable word, and its group's parent output is then raised. Each aggregated parent output has its own constant group mask, so one pending source can feed a different parent line than another. Software reaches the two words through an 8-byte read/write window. A pending bit is cleared by writing 1 to its position. The enable word only changes through a full-word write, because the window has no separate set or clear aliases.

Some sources, typically serial-port interrupts, are routed around the aggregation entirely. A constant bypass mask gives each such source its own parent output, which follows the raw input combinationally. Such a source never appears in the pending word. Bit positions that belong to no group and are not bypassed are unwired. An optional wake output reports that any enabled source is pending.

Top module: `l2_irq_agg`

## Requirements
- R1: Byte offset 0 (address bit 2 low) holds the enable word. A write there replaces all 32 bits, and a read returns the stored value. The enable word is zero after reset.
- R2: Byte offset 4 (address bit 2 high) reads the pending word. A rising edge on a grouped source, seen between two consecutive clock edges, sets its pending bit at the edge. The bit stays set until it is cleared.
- R3: A write to offset 4 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a source edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Pending bits for bypassed positions (default bits 0 to 2) and for unwired positions (default bits 12 to 31) always read 0. Edges on those sources never raise an aggregated output or wake.
- R6: Aggregated output g is a register. It is high one clock after a cycle in which some source in group g (default group 0 = 0x0000_0EB8, group 1 = 0x0000_0140) is both pending and enabled.
- R7: Each bypass output equals its raw source input combinationally, regardless of the enable word, the pending word and reset. Bypass outputs for non-bypassed positions are 0.
- R8: During and after reset, all aggregated outputs and the wake output are 0.
- R9: When wake is configured, the wake output is high one clock after a cycle in which any grouped source is both pending and enabled.
- R10: A write to offset 4 leaves the enable word unchanged. A write to offset 0 does not clear any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| src_i | input | 32 | Source interrupt lines, active high, synchronous to clk |
| wr_i | input | 1 | Write strobe for the register window |
| addr_i | input | 3 | Byte address within the window; bit 2 selects the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word addressed by addr_i |
| grp_irq_o | output | 2 | Registered aggregated outputs, one per group |
| fwd_irq_o | output | 32 | Bypass outputs, one per source position |
| wake_o | output | 1 | Registered wake indication |

## Verification
Two functions can collide in a single cycle: a new edge on a source, and a software write that clears the same pending bit. The bench provokes this directly. It lowers a grouped source, then raises it again in the very cycle that clears that bit. The pending word must read back with the bit still set. Random phases repeat the collision at random, because writes mixing ones and zeros land while sparse source bits toggle. Each read is compared with a bench model in which a set outranks a clear.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;

  localparam int unsigned SRC_W = 32;

  // word selected by address bit 2
  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_PENDING = 1'b1
  } win_sel_e;

  localparam logic [SRC_W-1:0] DEF_GRP0   = 32'h0000_0EB8;
  localparam logic [SRC_W-1:0] DEF_GRP1   = 32'h0000_0140;
  localparam logic [SRC_W-1:0] DEF_BYPASS = 32'h0000_0007;

endpackage

// File: rtl/l2_irq_rst_sync.sv
module l2_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];

endmodule

// File: rtl/l2_irq_regs.sv
module l2_irq_regs
  import l2_irq_pkg::*;
#(
  parameter int unsigned     NSRC = 32,
  parameter logic [NSRC-1:0] ELIG = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_i,
  input  win_sel_e        sel_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o
);

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] en_q, en_d;
  logic            en_we;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr;

  // edge capture and pending next state
  always_comb begin
    rise   = src_i & ~src_q & ELIG;
    clr    = (wr_i && sel_i == SEL_PENDING) ? wdata_i : '0;
    // a new edge outranks a clear of the same bit
    pend_d = ((pend_q & ~clr) | rise) & ELIG;
  end

  always_comb begin
    en_we = wr_i && (sel_i == SEL_ENABLE);
    en_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_comb begin
    unique case (sel_i)
      SEL_ENABLE:  rdata_o = en_q;
      SEL_PENDING: rdata_o = pend_q;
      default:     rdata_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/l2_irq_group.sv
module l2_irq_group #(
  parameter int unsigned     NSRC = 32,
  parameter logic [NSRC-1:0] MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_o
);

  logic hit_d;
  logic irq_q;

  always_comb begin
    hit_d = |(pend_i & en_i & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit_d;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/l2_irq_agg.sv
module l2_irq_agg
  import l2_irq_pkg::*;
#(
  parameter int unsigned                NSRC    = SRC_W,
  parameter int unsigned                NOUT    = 2,
  parameter logic [NOUT-1:0][NSRC-1:0]  GRP_MASK = {DEF_GRP1, DEF_GRP0},
  parameter logic [NSRC-1:0]            BYP_MASK = DEF_BYPASS,
  parameter bit                         WAKE_EN  = 1'b1,
  parameter int unsigned                SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_i,
  input  logic [2:0]      addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic [NOUT-1:0] grp_irq_o,
  output logic [NSRC-1:0] fwd_irq_o,
  output logic            wake_o
);

  function automatic logic [NSRC-1:0] f_elig();
    logic [NSRC-1:0] acc;
    acc = '0;
    for (int g = 0; g < NOUT; g++) acc |= GRP_MASK[g];
    return acc & ~BYP_MASK;
  endfunction

  localparam logic [NSRC-1:0] ELIG = f_elig();

  logic            rst_n_s;
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] en_w;
  win_sel_e        sel;

  assign sel = win_sel_e'(addr_i[2]);

  l2_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  l2_irq_regs #(.NSRC(NSRC), .ELIG(ELIG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .src_i   (src_i),
    .wr_i    (wr_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pend_o  (pend_w),
    .en_o    (en_w)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_grp
    l2_irq_group #(.NSRC(NSRC), .MASK(GRP_MASK[g] & ~BYP_MASK)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .pend_i (pend_w),
      .en_i   (en_w),
      .irq_o  (grp_irq_o[g])
    );
  end

  if (WAKE_EN) begin : g_wake
    l2_irq_group #(.NSRC(NSRC), .MASK(ELIG)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .pend_i (pend_w),
      .en_i   (en_w),
      .irq_o  (wake_o)
    );
  end else begin : g_nowake
    assign wake_o = 1'b0;
  end

  // bypass muxes: raw line straight through, untouched by reset
  for (genvar i = 0; i < NSRC; i++) begin : g_byp
    if (BYP_MASK[i]) begin : g_on
      assign fwd_irq_o[i] = src_i[i];
    end else begin : g_off
      assign fwd_irq_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/l2_irq_agg_chk.sv
module l2_irq_agg_chk #(
  parameter int unsigned     NSRC = 32,
  parameter int unsigned     NOUT = 2,
  parameter logic [NSRC-1:0] ELIG = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            wr_i,
  input logic [2:0]      addr_i,
  input logic [NSRC-1:0] wdata_i,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] en_q,
  input logic [NOUT-1:0] grp_o
);

  logic [NSRC-1:0] src_p;
  logic [NSRC-1:0] edge_v;
  logic            pend_wr;
  logic            en_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_p <= '0;
    else        src_p <= src_i;
  end

  assign edge_v  = rst_n ? (src_i & ~src_p & ELIG) : '0;
  assign pend_wr = wr_i && addr_i[2];
  assign en_wr   = wr_i && !addr_i[2];

  AST_UNWIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ELIG) == '0);                                                      // R5

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(edge_v)) == $past(edge_v)));                        // R4

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));                    // R2

  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend_q & $past(pend_q & ~wdata_i)) == $past(pend_q & ~wdata_i))); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));                                                    // R10

  AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (grp_o == '0));                                              // R6

endmodule

bind l2_irq_agg l2_irq_agg_chk #(.NSRC(NSRC), .NOUT(NOUT), .ELIG(ELIG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .src_i   (src_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pend_q  (pend_w),
  .en_q    (en_w),
  .grp_o   (grp_irq_o)
);

// File: tb/l2_irq_agg_tb.sv
`timescale 1ns/1ps
module l2_irq_agg_tb;

  localparam logic [31:0] M0   = 32'h0000_0EB8;
  localparam logic [31:0] M1   = 32'h0000_0140;
  localparam logic [31:0] BYP  = 32'h0000_0007;
  localparam logic [31:0] EL   = (M0 | M1) & ~BYP;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        wr;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  grp;
  logic [31:0] fwd;
  logic        wake;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model state
  logic [31:0] m_pend, m_en, m_src;
  logic [1:0]  m_grp;
  logic        m_wake;

  always #2 clk = ~clk;

  l2_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .grp_irq_o(grp), .fwd_irq_o(fwd),
    .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_pend(input logic [31:0] p, input logic [31:0] s_old,
                                            input logic [31:0] s_new, input logic do_clr,
                                            input logic [31:0] c);
    logic [31:0] cl;
    cl = do_clr ? c : 32'h0;
    return ((p & ~cl) | (s_new & ~s_old)) & EL;
  endfunction

  // one cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic step(input logic [31:0] s, input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    src = s; wr = w; addr = a; wdata = d;
    #1;
    check("R7 bypass", fwd, s & BYP);
    if (a[2]) begin
      check("R2 pending read", rdata, m_pend);
      check("R5 unwired zero", rdata & ~EL, 32'h0);
    end else begin
      check("R1 enable read", rdata, m_en);
    end
    @(posedge clk);
    m_grp[0] = |(m_pend & m_en & M0);
    m_grp[1] = |(m_pend & m_en & M1);
    m_wake   = |(m_pend & m_en & EL);
    m_pend   = next_pend(m_pend, m_src, s, w && a[2], d);
    if (w && !a[2]) m_en = d;
    m_src = s;
    #1;
    check("R6 group out", {30'h0, grp}, {30'h0, m_grp});
    check("R9 wake", {31'h0, wake}, {31'h0, m_wake});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(m_src, 1'b0, 3'd4, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd5150));
    rst_n = 1'b0; src = 32'h7; wr = 1'b0; addr = 3'd0; wdata = 32'h0;
    m_pend = '0; m_en = '0; m_src = '0; m_grp = '0; m_wake = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 bypass in reset", fwd, 32'h7);
    check("R8 outputs in reset", {29'h0, wake, grp}, 32'h0);
    @(negedge clk);
    src = 32'h0;
    rst_n = 1'b1;
    idle(4);
    // R8 reset state read back
    step(32'h0, 1'b0, 3'd0, 32'h0);
    check("R8 enable after reset", rdata, 32'h0);

    // R1 enable everything, read back
    step(32'h0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    step(32'h0, 1'b0, 3'd0, 32'h0);
    check("R1 enable write", rdata, 32'hFFFF_FFFF);

    // R6 source 3 rises: group 0 high, group 1 low
    step(32'h8, 1'b0, 3'd4, 32'h0);
    step(32'h8, 1'b0, 3'd4, 32'h0);
    check("R6 grp0 set", {31'h0, grp[0]}, 32'h1);
    check("R6 grp1 quiet", {31'h0, grp[1]}, 32'h0);
    // R3 write zero keeps
    step(32'h8, 1'b1, 3'd4, 32'hFFFF_FFF7);
    step(32'h8, 1'b0, 3'd4, 32'h0);
    check("R3 zero keeps", rdata & 32'h8, 32'h8);
    // R3 write one clears; R10 enable untouched
    step(32'h8, 1'b1, 3'd4, 32'h8);
    step(32'h8, 1'b0, 3'd4, 32'h0);
    check("R3 one clears", rdata, 32'h0);
    step(32'h8, 1'b0, 3'd0, 32'h0);
    check("R10 enable kept", rdata, 32'hFFFF_FFFF);

    // R4 edge on bit 6 collides with its clear
    step(32'h40, 1'b0, 3'd4, 32'h0);
    step(32'h00, 1'b0, 3'd4, 32'h0);
    step(32'h40, 1'b1, 3'd4, 32'h40);
    step(32'h40, 1'b0, 3'd4, 32'h0);
    check("R4 set wins", rdata, 32'h40);
    check("R6 grp1 set", {31'h0, grp[1]}, 32'h1);
    // R10 enable write leaves pending
    step(32'h40, 1'b1, 3'd0, 32'h0);
    step(32'h40, 1'b0, 3'd4, 32'h0);
    check("R10 pending kept", rdata, 32'h40);
    // R9 enable zero: wake low although pending
    idle(2);
    check("R9 wake off", {31'h0, wake}, 32'h0);
    step(32'h40, 1'b1, 3'd0, 32'h40);
    idle(2);
    check("R9 wake on", {31'h0, wake}, 32'h1);
    step(32'h40, 1'b1, 3'd4, 32'h40);

    // R5 bypassed and unwired sources never pend
    step(32'h0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    step(32'h0010_0003, 1'b0, 3'd4, 32'h0);
    step(32'h0010_0003, 1'b0, 3'd4, 32'h0);
    check("R5 no pend", rdata, 32'h0);
    idle(1);
    check("R5 outputs quiet", {29'h0, wake, grp}, 32'h0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] s;
      logic        w;
      logic [2:0]  a;
      logic [31:0] d;
      s = m_src ^ ($urandom & $urandom & $urandom);
      w = ($urandom % 6) == 0;
      a = {$urandom % 2 == 0, 2'b00};
      d = a[2] ? ($urandom & $urandom) : $urandom;
      step(s, w, a, d);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule